// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Counter

This block is a small synchronous up-counter. It can be preset from a parallel data input, and several instances can be chained to build a wider counter. Counting and presetting both happen on the rising clock edge. The reset is active low. A parameter chooses whether the reset acts at once or waits for a clock edge. A second parameter chooses binary counting (modulo 2^WIDTH) or decade counting (modulo 10, 4 bits only).

The counter has two active-high enables, and both must be high for it to advance. They play different roles. The terminal-count output is the second enable ANDed with the maximum-count condition. The first enable has no effect on it.

To build a chain, the terminal-count output of one stage drives the second enable of the next stage. All stages share the clock, the reset, the load and the first enable. No external carry gate is needed.

In decade mode the codes 10 to 15 are illegal. The counter steps out of them along a fixed path and joins the 0 to 9 sequence within at most two counts.

Top module: `presettable_counter`

## Requirements
- R1: While `load_n_i` is 0 and reset is inactive, the next rising edge copies `data_i` into `count_o`, whatever the enables are.
- R2: While `rst_n_i` is 0, the count is forced to 0. This holds whatever the load input and both enables are.
- R3: With RST_KIND = RST_ASYNC, a low level on `rst_n_i` clears `count_o` without any clock edge.
- R4: With RST_KIND = RST_SYNC, a low `rst_n_i` changes nothing until the next rising edge, and the count is 0 after that edge.
- R5: With `load_n_i` = 1, the count goes up by one on a rising edge only when `en_p_i` and `en_t_i` are both 1. In every other case it holds its value.
- R6: The maximum count is 2^WIDTH-1 in binary mode and 9 in decade mode. Counting from the maximum gives 0.
- R7: `tc_o` is 1 exactly when `en_t_i` is 1 and `count_o` equals the maximum count. `en_p_i` has no effect on it.
- R8: In decade mode, counting from an illegal code follows a fixed path: 10 goes to 11, 11 to 4, 12 to 13, 13 to 4, 14 to 15 and 15 to 4.
- R9: In decade mode, `tc_o` is 0 while `count_o` holds any value from 10 to 15.
- R10: Four binary stages form a 16-bit counter when they share reset, load and `en_p_i`. Each stage's `en_t_i` is fed from the previous stage's `tc_o`, and the least significant stage takes the external `en_t_i`. The chain then behaves as one 16-bit counter, and the last stage's `tc_o` goes high at 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on its rising edge, except an asynchronous reset |
| rst_n_i | input | 1 | Active-low master reset; acts asynchronously or synchronously, as set by RST_KIND |
| load_n_i | input | 1 | Active-low parallel load request |
| data_i | input | WIDTH | Parallel preset value |
| en_p_i | input | 1 | Count enable that does not affect the terminal count |
| en_t_i | input | 1 | Count enable that also gates the terminal count; driven by the previous stage in a chain |
| count_o | output | WIDTH | Current count |
| tc_o | output | 1 | Terminal count: `en_t_i` AND count at its maximum |

## Verification
The hardest cases to reach are the carries deep in a four-stage chain, such as the step from 16'h0FFF to 16'h1000 and the wrap from 16'hFFFF to 0. Plain counting from reset would need thousands of cycles to reach them. The bench presets the chain just below each boundary and then counts through it. It also asserts reset halfway between edges, with load and both enables active, to show that the reset wins over them. It separates the immediate reset from the edge-timed one by sampling between edges. The illegal decade codes cannot be reached by counting, so each one is preset directly before a single count.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

   typedef enum logic {
      RST_ASYNC = 1'b0,
      RST_SYNC  = 1'b1
   } rst_kind_e;

   typedef enum logic {
      SEQ_BINARY = 1'b0,
      SEQ_DECADE = 1'b1
   } seq_kind_e;

   // highest legal count value for a given width and sequence
   function automatic int max_count(int width, seq_kind_e seq);
      if (seq == SEQ_DECADE) return 9;
      return (1 << width) - 1;
   endfunction

endpackage

// File: rtl/cnt_next.sv
module cnt_next #(
   parameter int                WIDTH    = 4,
   parameter cnt_pkg::seq_kind_e SEQ_KIND = cnt_pkg::SEQ_BINARY
) (
   input  logic [WIDTH-1:0] cur_i,
   input  logic             load_n_i,
   input  logic [WIDTH-1:0] data_i,
   input  logic             step_i,
   output logic [WIDTH-1:0] nxt_o
);
   localparam logic [WIDTH-1:0] MAX_VAL = WIDTH'(cnt_pkg::max_count(WIDTH, SEQ_KIND));

   logic [WIDTH-1:0] inc_val;

   generate
      if (SEQ_KIND == cnt_pkg::SEQ_DECADE) begin : g_decade
         always_comb begin
            if (cur_i < MAX_VAL)       inc_val = cur_i + WIDTH'(1);
            else if (cur_i == MAX_VAL) inc_val = '0;
            else if (cur_i[0])         inc_val = WIDTH'(4);
            else                       inc_val = cur_i + WIDTH'(1);
         end
      end else begin : g_binary
         always_comb inc_val = cur_i + WIDTH'(1);
      end
   endgenerate

   always_comb begin
      if (!load_n_i)   nxt_o = data_i;
      else if (step_i) nxt_o = inc_val;
      else             nxt_o = cur_i;
   end
endmodule

// File: rtl/cnt_state_reg.sv
module cnt_state_reg #(
   parameter int                WIDTH    = 4,
   parameter cnt_pkg::rst_kind_e RST_KIND = cnt_pkg::RST_ASYNC
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      if (RST_KIND == cnt_pkg::RST_ASYNC) begin : g_async
         always_ff @(posedge clk_i or negedge rst_n_i) begin
            if (!rst_n_i) q_o <= '0;
            else          q_o <= d_i;
         end
      end else begin : g_sync
         always_ff @(posedge clk_i) begin
            if (!rst_n_i) q_o <= '0;
            else          q_o <= d_i;
         end
      end
   endgenerate
endmodule

// File: rtl/cnt_terminal.sv
module cnt_terminal #(
   parameter int                WIDTH    = 4,
   parameter cnt_pkg::seq_kind_e SEQ_KIND = cnt_pkg::SEQ_BINARY
) (
   input  logic [WIDTH-1:0] cur_i,
   input  logic             en_t_i,
   output logic             tc_o
);
   localparam logic [WIDTH-1:0] MAX_VAL = WIDTH'(cnt_pkg::max_count(WIDTH, SEQ_KIND));

   logic at_max;

   generate
      if (SEQ_KIND == cnt_pkg::SEQ_DECADE) begin : g_decade
         // 9 is the only code with bits 3 and 0 set and bits 2..1 clear
         assign at_max = cur_i[3] & ~cur_i[2] & ~cur_i[1] & cur_i[0];
      end else begin : g_binary
         assign at_max = (cur_i == MAX_VAL);
      end
   endgenerate

   assign tc_o = en_t_i & at_max;
endmodule

// File: rtl/presettable_counter.sv
module presettable_counter #(
   parameter int                WIDTH    = 4,
   parameter cnt_pkg::rst_kind_e RST_KIND = cnt_pkg::RST_ASYNC,
   parameter cnt_pkg::seq_kind_e SEQ_KIND = cnt_pkg::SEQ_BINARY
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic             load_n_i,
   input  logic [WIDTH-1:0] data_i,
   input  logic             en_p_i,
   input  logic             en_t_i,
   output logic [WIDTH-1:0] count_o,
   output logic             tc_o
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("presettable_counter: WIDTH must be at least 1");
      end
      if (SEQ_KIND == cnt_pkg::SEQ_DECADE && WIDTH != 4) begin : g_bad_decade
         $error("presettable_counter: decade sequence needs WIDTH of 4");
      end
   endgenerate

   logic [WIDTH-1:0] cur_q;
   logic [WIDTH-1:0] nxt_d;
   logic             step;

   assign step = en_p_i & en_t_i;

   cnt_next #(.WIDTH(WIDTH), .SEQ_KIND(SEQ_KIND)) u_next (
      .cur_i    (cur_q),
      .load_n_i (load_n_i),
      .data_i   (data_i),
      .step_i   (step),
      .nxt_o    (nxt_d)
   );

   cnt_state_reg #(.WIDTH(WIDTH), .RST_KIND(RST_KIND)) u_reg (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .d_i     (nxt_d),
      .q_o     (cur_q)
   );

   cnt_terminal #(.WIDTH(WIDTH), .SEQ_KIND(SEQ_KIND)) u_term (
      .cur_i  (cur_q),
      .en_t_i (en_t_i),
      .tc_o   (tc_o)
   );

   assign count_o = cur_q;
endmodule

// File: rtl/cnt_checker.sv
module cnt_checker #(
   parameter int                WIDTH    = 4,
   parameter cnt_pkg::rst_kind_e RST_KIND = cnt_pkg::RST_ASYNC,
   parameter cnt_pkg::seq_kind_e SEQ_KIND = cnt_pkg::SEQ_BINARY
) (
   input logic             clk_i,
   input logic             rst_n_i,
   input logic             load_n_i,
   input logic [WIDTH-1:0] data_i,
   input logic             en_p_i,
   input logic             en_t_i,
   input logic [WIDTH-1:0] count_o,
   input logic             tc_o
);
   localparam logic [WIDTH-1:0] MAX_VAL = WIDTH'(cnt_pkg::max_count(WIDTH, SEQ_KIND));

   logic past_ok = 1'b0;
   always_ff @(posedge clk_i) past_ok <= 1'b1;

   AST_LOAD_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !load_n_i |=> count_o == $past(data_i)); // R1

   AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (load_n_i && !(en_p_i && en_t_i)) |=> $stable(count_o)); // R5

   AST_STEP_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (load_n_i && en_p_i && en_t_i && count_o < MAX_VAL)
      |=> count_o == $past(count_o) + WIDTH'(1)); // R5

   AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (load_n_i && en_p_i && en_t_i && count_o == MAX_VAL) |=> count_o == '0); // R6

   AST_TC_NEEDS_TE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      tc_o |-> en_t_i); // R7

   AST_TC_AT_MAX: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      tc_o |-> count_o == MAX_VAL); // R7

   generate
      if (RST_KIND == cnt_pkg::RST_ASYNC) begin : g_async_chk
         AST_ASYNC_CLEAR: assert property (@(posedge clk_i)
            !rst_n_i |-> count_o == '0); // R3
      end else begin : g_sync_chk
         AST_SYNC_CLEAR: assert property (@(posedge clk_i)
            (past_ok && $past(!rst_n_i)) |-> count_o == '0); // R4
      end
      if (SEQ_KIND == cnt_pkg::SEQ_DECADE) begin : g_dec_chk
         AST_ILLEGAL_PATH: assert property (@(posedge clk_i) disable iff (!rst_n_i)
            (load_n_i && en_p_i && en_t_i && count_o > MAX_VAL)
            |=> ($past(count_o[0]) ? count_o == WIDTH'(4)
                                   : count_o == $past(count_o) + WIDTH'(1))); // R8
         AST_ILLEGAL_NO_TC: assert property (@(posedge clk_i) disable iff (!rst_n_i)
            count_o > MAX_VAL |-> !tc_o); // R9
      end
   endgenerate
endmodule

bind presettable_counter cnt_checker #(
   .WIDTH(WIDTH), .RST_KIND(RST_KIND), .SEQ_KIND(SEQ_KIND)
) u_chk (
   .clk_i    (clk_i),
   .rst_n_i  (rst_n_i),
   .load_n_i (load_n_i),
   .data_i   (data_i),
   .en_p_i   (en_p_i),
   .en_t_i   (en_t_i),
   .count_o  (count_o),
   .tc_o     (tc_o)
);

// File: tb/test_presettable_counter.sv
module test_presettable_counter;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // ---------------- four-stage binary chain, asynchronous reset --------------
   logic        c_rst_n, c_load_n, c_en_p, c_en_t;
   logic [15:0] c_data;
   logic [15:0] c_cnt;
   logic [3:0]  c_tc, c_te;

   for (genvar k = 0; k < 4; k++) begin : g_stage
      if (k == 0) begin : g_first
         assign c_te[k] = c_en_t;
      end else begin : g_rest
         assign c_te[k] = c_tc[k-1];
      end
      presettable_counter #(
         .WIDTH(4), .RST_KIND(cnt_pkg::RST_ASYNC), .SEQ_KIND(cnt_pkg::SEQ_BINARY)
      ) u_stage (
         .clk_i    (clk),
         .rst_n_i  (c_rst_n),
         .load_n_i (c_load_n),
         .data_i   (c_data[4*k +: 4]),
         .en_p_i   (c_en_p),
         .en_t_i   (c_te[k]),
         .count_o  (c_cnt[4*k +: 4]),
         .tc_o     (c_tc[k])
      );
   end

   // ---------------- single decade stage, synchronous reset -------------------
   logic       d_rst_n, d_load_n, d_en_p, d_en_t;
   logic [3:0] d_data, d_cnt;
   logic       d_tc;

   presettable_counter #(
      .WIDTH(4), .RST_KIND(cnt_pkg::RST_SYNC), .SEQ_KIND(cnt_pkg::SEQ_DECADE)
   ) i_presettable_counter (
      .clk_i    (clk),
      .rst_n_i  (d_rst_n),
      .load_n_i (d_load_n),
      .data_i   (d_data),
      .en_p_i   (d_en_p),
      .en_t_i   (d_en_t),
      .count_o  (d_cnt),
      .tc_o     (d_tc)
   );

   // ---------------- reference models ----------------------------------------
   int c_ref = 0;
   int d_ref = 0;

   function automatic int dec_after(int v);
      case (v)
         9:       return 0;
         10:      return 11;
         11:      return 4;
         12:      return 13;
         13:      return 4;
         14:      return 15;
         15:      return 4;
         default: return v + 1;
      endcase
   endfunction

   always @(posedge clk or negedge c_rst_n) begin
      if (!c_rst_n)                  c_ref <= 0;
      else if (!c_load_n)            c_ref <= int'(c_data);
      else if (c_en_p && c_en_t)     c_ref <= (c_ref + 1) % 65536;
   end

   always @(posedge clk) begin
      if (!d_rst_n)                  d_ref <= 0;
      else if (!d_load_n)            d_ref <= int'(d_data);
      else if (d_en_p && d_en_t)     d_ref <= dec_after(d_ref);
   end

   // ---------------- checking helpers ----------------------------------------
   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic compare_all();
      chk("R10 chain count", 32'(c_cnt), 32'(c_ref));
      chk("R10 chain tc", 32'(c_tc[3]), 32'(c_en_t && c_ref == 65535));
      chk("R5 decade count", 32'(d_cnt), 32'(d_ref));
      chk("R7 decade tc", 32'(d_tc), 32'(d_en_t && d_ref == 9));
   endtask

   task automatic tick();
      @(negedge clk);
      compare_all();
   endtask

   // ---------------- stimulus -------------------------------------------------
   initial begin
      c_rst_n = 0; c_load_n = 1; c_en_p = 0; c_en_t = 0; c_data = '0;
      d_rst_n = 0; d_load_n = 1; d_en_p = 0; d_en_t = 0; d_data = '0;
      repeat (3) tick();
      chk("R2 reset state chain", 32'(c_cnt), 32'd0);
      chk("R2 reset state decade", 32'(d_cnt), 32'd0);
      c_rst_n = 1; d_rst_n = 1;

      // R1: load with both enables low
      c_load_n = 0; c_data = 16'h1234; d_load_n = 0; d_data = 4'd7;
      tick();
      chk("R1 chain load", 32'(c_cnt), 32'h1234);
      chk("R1 decade load", 32'(d_cnt), 32'd7);
      c_load_n = 1; d_load_n = 1;

      // R5: one enable alone holds
      c_en_p = 1; c_en_t = 0; d_en_p = 1; d_en_t = 0;
      repeat (2) tick();
      chk("R5 hold en_t low", 32'(c_cnt), 32'h1234);
      c_en_p = 0; c_en_t = 1; d_en_p = 0; d_en_t = 1;
      tick();
      chk("R5 hold en_p low", 32'(d_cnt), 32'd7);

      // plain counting
      c_en_p = 1; d_en_p = 1;
      repeat (40) tick();

      // R6/R7: approach maximum and wrap
      c_load_n = 0; c_data = 16'hFFFE; d_load_n = 0; d_data = 4'd8;
      tick();
      c_load_n = 1; d_load_n = 1;
      tick();
      chk("R7 chain tc at max", 32'(c_tc[3]), 32'd1);
      chk("R7 decade tc at 9", 32'(d_tc), 32'd1);
      tick();
      chk("R6 chain wrap", 32'(c_cnt), 32'd0);
      chk("R6 decade wrap", 32'(d_cnt), 32'd0);

      // R7: en_p has no effect on tc, en_t does
      c_en_p = 0; d_en_p = 0;
      c_load_n = 0; c_data = 16'hFFFF; d_load_n = 0; d_data = 4'd9;
      tick();
      c_load_n = 1; d_load_n = 1;
      chk("R7 tc with en_p low chain", 32'(c_tc[3]), 32'd1);
      chk("R7 tc with en_p low decade", 32'(d_tc), 32'd1);
      c_en_t = 0; d_en_t = 0;
      #1;
      chk("R7 tc follows en_t chain", 32'(c_tc[3]), 32'd0);
      chk("R7 tc follows en_t decade", 32'(d_tc), 32'd0);
      c_en_t = 1; d_en_t = 1;

      // R10: deep carry across stages
      c_load_n = 0; c_data = 16'h0FFF;
      tick();
      c_load_n = 1; c_en_p = 1;
      tick();
      chk("R10 carry into stage 3", 32'(c_cnt), 32'h1000);
      repeat (300) tick();

      // R8/R9: every illegal decade code
      for (int v = 10; v < 16; v++) begin
         d_load_n = 0; d_data = 4'(v); d_en_p = 1; d_en_t = 1;
         tick();
         chk("R9 no tc on illegal code", 32'(d_tc), 32'd0);
         d_load_n = 1;
         tick();
         chk("R8 illegal step", 32'(d_cnt), 32'(dec_after(v)));
      end

      // R3/R2: asynchronous reset mid-cycle, load and enables active
      c_load_n = 0; c_data = 16'hABCD;
      tick();
      c_load_n = 1;
      tick();
      c_rst_n = 0; c_load_n = 0;
      #1;
      chk("R3 async clear before edge", 32'(c_cnt), 32'd0);
      tick();
      chk("R2 reset beats load", 32'(c_cnt), 32'd0);
      c_rst_n = 1; c_load_n = 1;

      // R4/R2: synchronous reset waits for the edge
      d_load_n = 0; d_data = 4'd5;
      tick();
      d_load_n = 1; d_en_p = 0;
      tick();
      d_rst_n = 0; d_load_n = 0; d_en_p = 1;
      #1;
      chk("R4 sync reset waits", 32'(d_cnt), 32'd5);
      tick();
      chk("R4 sync clear at edge", 32'(d_cnt), 32'd0);
      d_rst_n = 1; d_load_n = 1;

      // mixed random traffic
      for (int i = 0; i < 3000; i++) begin
         int r;
         r = int'($urandom % 100);
         c_rst_n  = !(r < 2);
         c_load_n = !(r >= 2 && r < 7);
         c_data   = 16'($urandom);
         c_en_p   = ($urandom % 8) != 0;
         c_en_t   = ($urandom % 8) != 0;
         r = int'($urandom % 100);
         d_rst_n  = !(r < 2);
         d_load_n = !(r >= 2 && r < 10);
         d_data   = 4'($urandom);
         d_en_p   = ($urandom % 4) != 0;
         d_en_t   = ($urandom % 4) != 0;
         tick();
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_bad++;
         $display("FAIL R10 watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule